// File: doc/BRIEF.md
# Stop-State Oscillator Request Arbiter

While the chip sits in a stop state with its oscillators powered down, a few peripherals must still be able to catch an incoming frame. This block lets each of those peripherals ask for the internal high-speed oscillator. When at least one slot asks, the block enables the oscillator. Once the oscillator reports ready, the block opens a clock gate only for the slots that are asking. All other slots stay gated.

At the end of each frame the peripheral reports whether the frame should wake the system. For a wakeup frame the block raises a sticky wakeup request toward the power controller. For any other frame the slot loses its grant. If no other slot is still being served, the oscillator is switched off again. A settle counter then keeps the oscillator disabled for a minimum time, so that it cannot cycle on and off rapidly. Outside the stop state, the requests pass straight through to the gates and the block leaves the oscillator enable low, because run-mode clock control owns the oscillator there.

The default build has nine slots: three serial-bus controllers, five UARTs and one low-power UART. The slot count and the settle length are parameters.

Top module: `osc_req_arbiter`

## Requirements
- R1: While `stop_mode` is low, `clk_gate` equals `clk_req` in the same cycle, and `osc_en` and `wake_req` are low.
- R2: After reset, and in the stop state with no slot being served, `osc_en` is low and every `clk_gate` bit is low.
- R3: In the stop state, if a slot raises `clk_req` while the settle counter is idle, `osc_en` goes high after the second rising clock edge.
- R4: In the stop state, `clk_gate[i]` is high only while `osc_en` and `osc_ready` are both high and slot i holds a grant. Slots without a grant stay gated.
- R5: A `frame_done` pulse with `frame_wake` low on a served slot closes that slot's gate after the next edge. If no other slot is served, `osc_en` falls one edge later.
- R6: After such a drop, the slot is not served again while its `clk_req` stays high. It must take `clk_req` low before it can make a new request.
- R7: Once `osc_en` falls, it stays low for at least SETTLE further clock edges, even if new requests arrive. After that it rises on the next edge.
- R8: A `frame_done` pulse with `frame_wake` high on a served slot sets `wake_req` after the next edge. `wake_req` stays high until `stop_mode` goes low, and the slot keeps its gate open.
- R9: The end of a frame on one slot leaves the grants and gates of all other slots, and `osc_en`, unchanged.
- R10: `frame_done` and `frame_wake` pulses on a slot that holds no grant are ignored. They set no `wake_req` and do not enable the oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock for the control logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_mode | input | 1 | High while the device is in the stop state |
| clk_req | input | NSLOT | Per-slot level request for the oscillator clock |
| osc_ready | input | 1 | Oscillator output is stable |
| frame_done | input | NSLOT | One-cycle pulse: the slot finished receiving a frame |
| frame_wake | input | NSLOT | Qualifies `frame_done`: high when the frame is a wakeup frame |
| osc_en | output | 1 | Oscillator enable, driven in the stop state only |
| clk_gate | output | NSLOT | Per-slot clock gate enable |
| wake_req | output | 1 | Sticky system wakeup request |

## Verification
The assertions assume that `frame_done` is a single-cycle pulse, that `frame_wake` matters only in the cycle when `frame_done` is high, and that `stop_mode` changes only between frames. The stimulus drives every input just after a falling edge. It raises `frame_done` for exactly one edge and changes `stop_mode` only while no frame is pending. It raises `osc_ready` only after `osc_en` has been seen high, and it lowers it again after the oscillator is released. This mirrors a real oscillator that cannot report ready while disabled.

// File: rtl/osc_arb_pkg.sv
package osc_arb_pkg;

  typedef enum logic [1:0] {
    SL_IDLE    = 2'd0,
    SL_ACTIVE  = 2'd1,
    SL_BLOCKED = 2'd2
  } slot_state_e;

  // Next value of a down counter that can be reloaded.
  function automatic int unsigned settle_next(input int unsigned cur,
                                              input logic        load,
                                              input int unsigned span);
    if (load) return span;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

  // Oscillator is allowed on only when requested and the hold-off has expired.
  function automatic logic osc_allowed(input logic stop,
                                       input logic anyone,
                                       input logic idle);
    return stop & anyone & idle;
  endfunction

endpackage

// File: rtl/osc_slot.sv
module osc_slot
  import osc_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_mode,
  input  logic req,
  input  logic done,
  input  logic wake,
  output logic served,
  output logic wake_hit
);

  slot_state_e state_q, state_d;
  logic        plain_end;

  assign plain_end = stop_mode & (state_q == SL_ACTIVE) & done & ~wake;
  assign wake_hit  = stop_mode & (state_q == SL_ACTIVE) & done & wake;
  assign served    = (state_q == SL_ACTIVE);

  always_comb begin
    state_d = state_q;
    if (!stop_mode) begin
      state_d = SL_IDLE;
    end else begin
      unique case (state_q)
        SL_IDLE:    if (req) state_d = SL_ACTIVE;
        SL_ACTIVE: begin
          if (plain_end)  state_d = SL_BLOCKED;
          else if (!req)  state_d = SL_IDLE;
        end
        SL_BLOCKED: if (!req) state_d = SL_IDLE;
        default:    state_d = SL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SL_IDLE;
    else        state_q <= state_d;
  end

  // R5: a non-wake frame end withdraws the grant
  a_r5_plain_end_drops: assert property (@(posedge clk) disable iff (!rst_n)
    plain_end |=> (state_q != SL_ACTIVE));

  // R6: a dropped slot cannot regain its grant without releasing the request
  a_r6_blocked_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SL_BLOCKED) |=> (state_q != SL_ACTIVE));

endmodule

// File: rtl/osc_settle.sv
module osc_settle
  import osc_arb_pkg::*;
#(
  parameter int unsigned SETTLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_mode,
  input  logic any_served,
  output logic en_q,
  output logic holdoff
);

  localparam int unsigned CW = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);

  logic [CW-1:0] cnt_q;
  logic          en_d;
  logic          falling;

  assign holdoff = (cnt_q != '0);
  assign en_d    = osc_allowed(stop_mode, any_served, ~holdoff);
  assign falling = en_q & ~en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q  <= en_d;
      cnt_q <= CW'(settle_next(int'(cnt_q), falling, SETTLE));
    end
  end

  // R7: oscillator kept off while the hold-off counter runs
  a_r7_settle_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    holdoff |-> !en_q);

endmodule

// File: rtl/osc_req_arbiter.sv
module osc_req_arbiter
  import osc_arb_pkg::*;
#(
  parameter int unsigned NSLOT  = 9,
  parameter int unsigned SETTLE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_mode,
  input  logic [NSLOT-1:0] clk_req,
  input  logic             osc_ready,
  input  logic [NSLOT-1:0] frame_done,
  input  logic [NSLOT-1:0] frame_wake,
  output logic             osc_en,
  output logic [NSLOT-1:0] clk_gate,
  output logic             wake_req
);

  logic [NSLOT-1:0] served;
  logic [NSLOT-1:0] wake_hit;
  logic             any_served;
  logic             en_q;
  logic             holdoff;
  logic             wake_q;
  logic             clock_live;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    osc_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_mode (stop_mode),
      .req       (clk_req[i]),
      .done      (frame_done[i]),
      .wake      (frame_wake[i]),
      .served    (served[i]),
      .wake_hit  (wake_hit[i])
    );
    assign clk_gate[i] = stop_mode ? (served[i] & clock_live) : clk_req[i];
  end

  assign any_served = |served;
  assign clock_live = en_q & osc_ready;

  osc_settle #(.SETTLE(SETTLE)) u_settle (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_mode  (stop_mode),
    .any_served (any_served),
    .en_q       (en_q),
    .holdoff    (holdoff)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wake_q <= 1'b0;
    else if (!stop_mode) wake_q <= 1'b0;
    else if (|wake_hit)  wake_q <= 1'b1;
  end

  assign osc_en   = stop_mode & en_q;
  assign wake_req = wake_q;

  // R2: no served slot means the oscillator is off after the next edge
  a_r2_idle_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
    !any_served |=> !osc_en);

  // R8: wakeup request is held for the rest of the stop state
  a_r8_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && $past(stop_mode) && $past(wake_req)) |-> wake_req);

  // R1: no wakeup request outside the stop state
  a_r1_no_wake_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stop_mode) |-> !wake_req);

endmodule

// File: tb/tb_osc_req_arbiter.sv
module tb_osc_req_arbiter;

  localparam int NS = 9;
  localparam int ST = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stop_mode;
  logic [NS-1:0] clk_req;
  logic          osc_ready;
  logic [NS-1:0] frame_done;
  logic [NS-1:0] frame_wake;
  logic          osc_en;
  logic [NS-1:0] clk_gate;
  logic          wake_req;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  osc_req_arbiter #(.NSLOT(NS), .SETTLE(ST)) dut (
    .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .clk_req(clk_req),
    .osc_ready(osc_ready), .frame_done(frame_done), .frame_wake(frame_wake),
    .osc_en(osc_en), .clk_gate(clk_gate), .wake_req(wake_req)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_frame(input int slot, input logic is_wake);
    frame_done[slot] = 1'b1;
    frame_wake[slot] = is_wake;
    tick(1);
    frame_done = '0;
    frame_wake = '0;
  endtask

  task automatic release_all();
    clk_req = '0;
    tick(1);
    osc_ready = 1'b0;
    tick(ST + 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stop_mode = 1'b0; clk_req = '0; osc_ready = 1'b0;
    frame_done = '0; frame_wake = '0;
    #1;
    chk("R2 reset osc_en", NS'(osc_en), '0);
    chk("R2 reset gates", clk_gate, '0);
    chk("R2 reset wake", NS'(wake_req), '0);
    tick(2);
    rst_n = 1'b1;
    tick(1);

    // R1: pass-through sweep over every request pattern outside stop
    for (int v = 0; v < (1 << NS); v++) begin
      clk_req = NS'(v);
      #1;
      chk("R1 passthrough", clk_gate, NS'(v));
      chk("R1 osc_en low", NS'(osc_en), '0);
    end
    clk_req = '0;

    // R2: stop with nobody asking
    stop_mode = 1'b1;
    tick(3);
    chk("R2 idle osc_en", NS'(osc_en), '0);
    chk("R2 idle gates", clk_gate, '0);

    // per-slot sequence: R3 R4 R5 R6
    for (int i = 0; i < NS; i++) begin
      clk_req = NS'(1) << i;
      tick(1);
      chk("R3 osc_en not yet", NS'(osc_en), '0);
      tick(1);
      chk("R3 osc_en on", NS'(osc_en), NS'(1));
      chk("R4 gate waits for ready", clk_gate, '0);
      osc_ready = 1'b1;
      #1;
      chk("R4 only requester gated", clk_gate, NS'(1) << i);
      tick(1);
      pulse_frame(i, 1'b0);
      chk("R5 gate closed", clk_gate, '0);
      chk("R5 osc_en still on", NS'(osc_en), NS'(1));
      tick(1);
      chk("R5 osc_en off", NS'(osc_en), '0);
      osc_ready = 1'b0;
      tick(ST + 3);
      chk("R6 blocked gate", clk_gate, '0);
      chk("R6 blocked osc_en", NS'(osc_en), '0);
      release_all();
    end

    // R7: settle hold-off
    clk_req = NS'(1);
    tick(2);
    osc_ready = 1'b1;
    pulse_frame(0, 1'b0);
    tick(1);
    chk("R7 fall", NS'(osc_en), '0);
    osc_ready = 1'b0;
    clk_req = NS'(3);
    for (int m = 1; m <= ST; m++) begin
      tick(1);
      chk("R7 held off", NS'(osc_en), '0);
    end
    tick(1);
    chk("R7 back on", NS'(osc_en), NS'(1));
    osc_ready = 1'b1;
    #1;
    chk("R7 only slot1 gated", clk_gate, NS'(2));
    release_all();

    // R9: every ordered pair, one ends a plain frame, the other keeps going
    for (int i = 0; i < NS; i++) begin
      for (int j = 0; j < NS; j++) begin
        if (i != j) begin
          clk_req = (NS'(1) << i) | (NS'(1) << j);
          tick(2);
          osc_ready = 1'b1;
          #1;
          chk("R4 pair gated", clk_gate, (NS'(1) << i) | (NS'(1) << j));
          pulse_frame(i, 1'b0);
          chk("R9 other slot kept", clk_gate, NS'(1) << j);
          tick(1);
          chk("R9 osc_en kept", NS'(osc_en), NS'(1));
          chk("R9 gate kept", clk_gate, NS'(1) << j);
          release_all();
        end
      end
    end

    // R8: wakeup frame
    clk_req = NS'(1) << 4;
    tick(2);
    osc_ready = 1'b1;
    chk("R8 no wake yet", NS'(wake_req), '0);
    pulse_frame(4, 1'b1);
    chk("R8 wake set", NS'(wake_req), NS'(1));
    chk("R8 slot still gated", clk_gate, NS'(1) << 4);
    tick(3);
    chk("R8 wake held", NS'(wake_req), NS'(1));
    stop_mode = 1'b0;
    tick(1);
    chk("R8 wake cleared", NS'(wake_req), '0);
    chk("R1 osc_en low in run", NS'(osc_en), '0);
    release_all();

    // R10: strobes on slots without a grant
    stop_mode = 1'b1;
    tick(2);
    frame_done = '1;
    frame_wake = '1;
    tick(1);
    frame_done = '0;
    frame_wake = '0;
    chk("R10 no wake", NS'(wake_req), '0);
    tick(1);
    chk("R10 osc stays off", NS'(osc_en), '0);
    chk("R10 gates closed", clk_gate, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule